// File: doc/BRIEF.md
# Per-Hart Interrupt Claim Unit

This block sits beside an interrupt source unit that owns each source's pending and enable bits. It holds one routing word per source whose upper field names the hart that should service the source. From these words it builds one interrupt request line per hart. Each request is raised while the domain-wide enable input is high and some source routed to that hart is both pending and enabled.

Software on a hart takes an interrupt by reading the claim register in that hart's control window. The read picks the lowest-numbered pending source routed to the hart and returns its number. In the same step it pulses one bit of a clear strobe, which tells the source unit to drop that source's pending bit. Until the source unit reflects the clear, the unit itself masks any source whose strobe is in flight. Two claim reads on consecutive cycles therefore never return the same source.

All registers are reached over a simple register bus. A request is one cycle of `bus_valid`, and its response (`bus_ack`, `bus_rdata`, `bus_err`) appears in the following cycle. A two-state bus machine tracks the response slot:
- IDLE: no response is presented. IDLE to ACK happens when `bus_valid` is sampled high. IDLE to IDLE happens when it is low.
- ACK: a response is presented. ACK to ACK happens on a back-to-back request. ACK to IDLE happens when no request is sampled.

Top module: `hart_claim_unit`

## Requirements
- R1: A write to the routing word of source n (byte address 0x3000 + 4*n, n from 1 to NSRC) stores all 32 bits, and a later read returns the same word. Every request sampled with `bus_valid` high is answered with `bus_ack` high in the next cycle, and `bus_ack` is never high otherwise.
- R2: Bits 31:18 of the routing word (14 bits) name the hart of the source. A source whose hart value is NHART or more is routed to no hart, and bits 17:0 have no effect on routing.
- R3: A read of hart h's claim register (address 0x4000 + 32*h + 0x1C) returns the lowest-numbered source that is pending and routed to h. The source number is in bits 25:16, and all other bits are zero.
- R4: A claim read that returns source n drives `clr_pend` with exactly bit n-1 set in the response cycle, and with zero in the next cycle unless a new claim succeeds. A claim read in the cycle right after a successful claim does not return the source just claimed.
- R5: A claim read with no qualifying source returns zero, reports no error, and leaves `clr_pend` at zero.
- R6: A write to a claim register reports no error and drives no clear, and the source it could have claimed stays claimable.
- R7: Offsets 0x00, 0x04, 0x08 and 0x18 in a hart window read as zero without error. Writes to them have no visible effect.
- R8: The following report `bus_err` with `bus_rdata` zero: any other offset in a window, any address at or past 0x4000 + 32*NHART, a misaligned address, and any address outside the routing words and windows.
- R9: `hart_irq[h]` is high only while `dom_en` is high and some source routed to h is pending and enabled. A source whose clear is in flight does not count.
- R10: The claim scan ignores the enable bits, so a pending but disabled source is still returned by a claim read.
- R11: After reset all routing words are zero (all sources to hart 0), and `bus_ack`, `bus_err`, `bus_rdata` and `clr_pend` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response valid, one cycle after the request |
| bus_rdata | output | 32 | Read data of the response |
| bus_err | output | 1 | Access error of the response |
| dom_en | input | 1 | Domain-wide interrupt enable |
| src_pend | input | NSRC | Pending bits from the source unit, bit n-1 for source n |
| src_en | input | NSRC | Enable bits from the source unit, bit n-1 for source n |
| clr_pend | output | NSRC | One-cycle clear-pending strobe to the source unit |
| hart_irq | output | NHART | Interrupt request per hart |

## Verification
The scan of a claim read can coincide with the clear of the previous claim still being in flight. In that cycle `src_pend` still shows the source just claimed, and only the internal mask keeps it from being returned twice. The bench provokes this with back-to-back claim reads on one hart, both directed and at random, against a model of the source unit that drops pending bits only on the edge after the strobe. It judges the second read, and the request line sampled in the same cycle, against a model whose pending set already excludes the claimed source.

// File: rtl/hcu_pkg.sv
package hcu_pkg;
    localparam int TGT_BASE   = 'h3000;
    localparam int IDC_BASE   = 'h4000;
    localparam int IDC_STRIDE = 32;
    localparam int HART_LSB   = 18;
    localparam int HART_W     = 14;
    localparam int NUM_LSB    = 16;

    typedef enum logic [1:0] {
        ACC_ERR,
        ACC_TGT,
        ACC_CLAIM,
        ACC_ZERO
    } acc_e;

    typedef enum logic {
        ST_IDLE,
        ST_ACK
    } bus_st_e;
endpackage

// File: rtl/hcu_addr_dec.sv
module hcu_addr_dec
    import hcu_pkg::*;
#(
    parameter int NSRC  = 31,
    parameter int NHART = 4,
    parameter int AW    = 16,
    parameter int SW    = 5,
    parameter int HW    = 2
) (
    input  logic [AW-1:0] addr,
    output acc_e          kind,
    output logic [SW-1:0] src,
    output logic [HW-1:0] hart
);
    localparam logic [AW-1:0] TGT_LO  = AW'(TGT_BASE + 4);
    localparam logic [AW-1:0] TGT_HI  = AW'(TGT_BASE + 4 * NSRC);
    localparam logic [AW-1:0] IDC_LO  = AW'(IDC_BASE);
    localparam logic [AW-1:0] IDC_END = AW'(IDC_BASE + IDC_STRIDE * NHART);

    assign src  = SW'((addr - AW'(TGT_BASE)) >> 2);
    assign hart = HW'((addr - IDC_LO) >> 5);

    always_comb begin
        kind = ACC_ERR;
        if (addr[1:0] == 2'b00) begin
            if (addr >= TGT_LO && addr <= TGT_HI) begin
                kind = ACC_TGT;
            end else if (addr >= IDC_LO && addr < IDC_END) begin
                unique case (addr[4:0])
                    5'h1C:                      kind = ACC_CLAIM;
                    5'h00, 5'h04, 5'h08, 5'h18: kind = ACC_ZERO;
                    default:                    kind = ACC_ERR;
                endcase
            end
        end
    end
endmodule

// File: rtl/hcu_target_regs.sv
module hcu_target_regs
    import hcu_pkg::*;
#(
    parameter int NSRC  = 31,
    parameter int NHART = 4,
    parameter int SW    = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [SW-1:0]               sel,
    input  logic [31:0]                 wdata,
    output logic [31:0]                 rdata,
    output logic [NHART-1:0][NSRC-1:0]  route
);
    logic [NSRC*32-1:0] words;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic [31:0] word_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (we && sel == SW'(s + 1)) begin
                word_q <= wdata;
            end
        end

        assign words[s*32 +: 32] = word_q;

        for (genvar h = 0; h < NHART; h++) begin : g_hart
            assign route[h][s] = (word_q[HART_LSB +: HART_W] == HART_W'(h));
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SW'(i + 1)) begin
                rdata = words[i*32 +: 32];
            end
        end
    end
endmodule

// File: rtl/hcu_claim_scan.sv
module hcu_claim_scan #(
    parameter int NSRC  = 31,
    parameter int NHART = 4,
    parameter int SW    = 5
) (
    input  logic [NSRC-1:0]             pend,
    input  logic [NSRC-1:0]             en,
    input  logic                        dom_en,
    input  logic [NHART-1:0][NSRC-1:0]  route,
    output logic [NHART-1:0]            found,
    output logic [NHART-1:0][SW-1:0]    num,
    output logic [NHART-1:0]            irq
);
    for (genvar h = 0; h < NHART; h++) begin : g_hart
        logic [NSRC-1:0] cand;
        logic [SW-1:0]   first;

        assign cand     = pend & route[h];
        assign found[h] = |cand;
        assign irq[h]   = dom_en & (|(cand & en));

        // lowest index wins: walk downward so the last hit is the smallest
        always_comb begin
            first = '0;
            for (int s = NSRC - 1; s >= 0; s--) begin
                if (cand[s]) begin
                    first = SW'(s + 1);
                end
            end
        end

        assign num[h] = first;
    end
endmodule

// File: rtl/hart_claim_unit.sv
module hart_claim_unit
    import hcu_pkg::*;
#(
    parameter int NSRC  = 31,
    parameter int NHART = 4,
    parameter int AW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [AW-1:0]    bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic             bus_ack,
    output logic [31:0]      bus_rdata,
    output logic             bus_err,
    input  logic             dom_en,
    input  logic [NSRC-1:0]  src_pend,
    input  logic [NSRC-1:0]  src_en,
    output logic [NSRC-1:0]  clr_pend,
    output logic [NHART-1:0] hart_irq
);
    localparam int SW = $clog2(NSRC + 1);
    localparam int HW = (NHART > 1) ? $clog2(NHART) : 1;

    acc_e                       kind;
    logic [SW-1:0]              src_sel;
    logic [HW-1:0]              hart_sel;
    logic [31:0]                tgt_rdata;
    logic [NHART-1:0][NSRC-1:0] route;
    logic [NHART-1:0]           found;
    logic [NHART-1:0][SW-1:0]   num;
    logic [NSRC-1:0]            eff_pend;
    logic [NSRC-1:0]            clr_q;
    logic [31:0]                rdata_q;
    logic                       err_q;
    logic [31:0]                rd_next;
    logic                       tgt_we;
    logic                       claim_rd;
    bus_st_e                    state_q;
    bus_st_e                    state_d;

    hcu_addr_dec #(
        .NSRC(NSRC), .NHART(NHART), .AW(AW), .SW(SW), .HW(HW)
    ) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .src  (src_sel),
        .hart (hart_sel)
    );

    assign tgt_we = bus_valid & bus_write & (kind == ACC_TGT);

    hcu_target_regs #(
        .NSRC(NSRC), .NHART(NHART), .SW(SW)
    ) u_tgt (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tgt_we),
        .sel   (src_sel),
        .wdata (bus_wdata),
        .rdata (tgt_rdata),
        .route (route)
    );

    // a source whose clear is still in flight is treated as already taken
    assign eff_pend = src_pend & ~clr_q;

    hcu_claim_scan #(
        .NSRC(NSRC), .NHART(NHART), .SW(SW)
    ) u_scan (
        .pend   (eff_pend),
        .en     (src_en),
        .dom_en (dom_en),
        .route  (route),
        .found  (found),
        .num    (num),
        .irq    (hart_irq)
    );

    assign claim_rd = bus_valid & ~bus_write & (kind == ACC_CLAIM) & found[hart_sel];

    always_comb begin
        rd_next = '0;
        unique case (kind)
            ACC_TGT:   rd_next = bus_write ? '0 : tgt_rdata;
            ACC_CLAIM: rd_next = claim_rd ? (32'(num[hart_sel]) << NUM_LSB) : '0;
            ACC_ZERO:  rd_next = '0;
            ACC_ERR:   rd_next = '0;
        endcase
    end

    // bus response state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = bus_valid ? ST_ACK : ST_IDLE;
            ST_ACK:  state_d = bus_valid ? ST_ACK : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs of the state machine
    always_comb begin
        bus_ack = (state_q == ST_ACK);
    end

    // response data and clear strobe, registered with the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
            clr_q   <= '0;
        end else begin
            rdata_q <= bus_valid ? rd_next : '0;
            err_q   <= bus_valid && (kind == ACC_ERR);
            clr_q   <= claim_rd ? (NSRC'(1) << (num[hart_sel] - SW'(1))) : '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;
    assign clr_pend  = clr_q;
endmodule

// File: rtl/hcu_checker.sv
module hcu_checker #(
    parameter int NSRC  = 31,
    parameter int NHART = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic             bus_ack,
    input logic [31:0]      bus_rdata,
    input logic             bus_err,
    input logic             dom_en,
    input logic [NSRC-1:0]  clr_pend,
    input logic [NHART-1:0] hart_irq
);
    assert_ack_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> bus_ack);

    assert_ack_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_valid));

    assert_clear_has_number_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend != '0) |-> (bus_ack && !bus_err && bus_rdata[7:0] == 8'd0
                              && bus_rdata[25:16] != 10'd0));

    assert_clear_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_pend));

    assert_no_repeat_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend != '0) |=> ((clr_pend & $past(clr_pend)) == '0));

    assert_clear_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend != '0) |-> $past(bus_valid && !bus_write));

    assert_err_zero_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_ack && bus_rdata == 32'd0));

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_en |-> (hart_irq == '0));
endmodule

bind hart_claim_unit hcu_checker #(.NSRC(NSRC), .NHART(NHART)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .dom_en    (dom_en),
    .clr_pend  (clr_pend),
    .hart_irq  (hart_irq)
);

// File: tb/sim_hart_claim_unit.sv
`timescale 1ns/1ps
module sim_hart_claim_unit;
    localparam int NSRC  = 31;
    localparam int NHART = 4;
    localparam int AW    = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic             bus_ack;
    logic [31:0]      bus_rdata;
    logic             bus_err;
    logic             dom_en = 1'b0;
    logic [NSRC-1:0]  pend_r;
    logic [NSRC-1:0]  raise = '0;
    logic [NSRC-1:0]  en_r = '0;
    logic [NSRC-1:0]  clr_pend;
    logic [NHART-1:0] hart_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [NSRC-1:0] exp_pend = '0;
    logic [31:0]     exp_tgt [NSRC+1];

    always #2.5 clk = ~clk;

    hart_claim_unit #(.NSRC(NSRC), .NHART(NHART), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .dom_en(dom_en),
        .src_pend(pend_r), .src_en(en_r), .clr_pend(clr_pend), .hart_irq(hart_irq)
    );

    // source unit model: pending drops on the edge after the clear strobe
    always @(posedge clk) begin
        if (!rst_n) pend_r <= '0;
        else        pend_r <= (pend_r & ~clr_pend) | raise;
    end

    function automatic int hart_of(logic [31:0] w);
        return int'(w[31:18]);
    endfunction

    function automatic int exp_claim(int h);
        for (int s = 1; s <= NSRC; s++)
            if (exp_pend[s-1] && hart_of(exp_tgt[s]) == h) return s;
        return 0;
    endfunction

    function automatic logic [NHART-1:0] exp_irq();
        logic [NHART-1:0] r = '0;
        for (int s = 1; s <= NSRC; s++)
            if (dom_en && exp_pend[s-1] && en_r[s-1] && hart_of(exp_tgt[s]) < NHART)
                r[hart_of(exp_tgt[s])] = 1'b1;
        return r;
    endfunction

    function automatic logic [NSRC-1:0] bit_of(int s);
        logic [NSRC-1:0] b = '0;
        if (s > 0) b[s-1] = 1'b1;
        return b;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_op(bit w, logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic raise_src(logic [NSRC-1:0] bits);
        @(negedge clk);
        raise = bits;
        exp_pend = exp_pend | bits;
        @(posedge clk); #1;
        raise = '0;
    endtask

    task automatic set_en(logic [NSRC-1:0] e, bit d);
        @(negedge clk);
        en_r = e; dom_en = d;
    endtask

    task automatic check_irq(string tag);
        chk(tag, 32'(hart_irq), 32'(exp_irq()));
    endtask

    task automatic wr_tgt(int s, logic [31:0] v);
        bus_op(1'b1, AW'(32'h3000 + 4 * s), v);
        exp_tgt[s] = v;
        chk("R1 target write no error", 32'(bus_err), 32'd0);
    endtask

    task automatic rd_tgt(int s, string tag);
        bus_op(1'b0, AW'(32'h3000 + 4 * s), 32'd0);
        chk(tag, bus_rdata, exp_tgt[s]);
        chk("R1 ack", 32'(bus_ack), 32'd1);
    endtask

    task automatic claim(int h, string tag);
        int e;
        bus_op(1'b0, AW'(32'h4000 + 32 * h + 'h1C), 32'd0);
        e = exp_claim(h);
        chk(tag, bus_rdata, 32'(e) << 16);
        chk("R4 clear strobe", 32'(clr_pend), 32'(bit_of(e)));
        chk("R5 claim no error", 32'(bus_err), 32'd0);
        if (e > 0) exp_pend[e-1] = 1'b0;
        check_irq("R9 irq after claim");
    endtask

    task automatic expect_err(logic [AW-1:0] a, bit w, string tag);
        bus_op(w, a, 32'hFFFF_FFFF);
        chk(tag, 32'(bus_err), 32'd1);
        chk("R8 error data zero", bus_rdata, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7341));
        for (int s = 0; s <= NSRC; s++) exp_tgt[s] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R11 ack reset", 32'(bus_ack), 32'd0);
        chk("R11 err reset", 32'(bus_err), 32'd0);
        chk("R11 rdata reset", bus_rdata, 32'd0);
        chk("R11 clear reset", 32'(clr_pend), 32'd0);
        rd_tgt(7, "R11 target reset value");

        // R1: full word stored
        wr_tgt(5, 32'h0004_0123);
        rd_tgt(5, "R1 target readback");
        @(posedge clk); #1;
        chk("R1 ack drops when idle", 32'(bus_ack), 32'd0);

        // R2/R3/R4: routing and ordered claims on hart 2
        wr_tgt(3, 32'h0008_0000);
        wr_tgt(7, 32'h0008_3FFF);
        wr_tgt(9, 32'h0000_0000);
        wr_tgt(12, 32'h0014_0000);
        raise_src(bit_of(7) | bit_of(3) | bit_of(12));
        set_en('0, 1'b1);
        check_irq("R9 enables off no irq");
        // R10: disabled sources are still claimable; R4 back-to-back
        claim(2, "R3 R10 first claim lowest");
        claim(2, "R4 back-to-back next source");
        claim(2, "R5 empty claim zero");
        claim(0, "R2 out-of-range hart not claimed");
        claim(1, "R2 hart1 nothing routed");

        // R9: irq gating
        raise_src(bit_of(9));
        set_en(bit_of(9), 1'b1);
        @(posedge clk); #1;
        check_irq("R9 irq with enable");
        chk("R9 hart0 irq high", 32'(hart_irq[0]), 32'd1);
        set_en(bit_of(9), 1'b0);
        @(posedge clk); #1;
        chk("R9 domain off irq low", 32'(hart_irq), 32'd0);
        set_en(bit_of(9), 1'b1);

        // R6: claim write ignored
        bus_op(1'b1, AW'(32'h4000 + 'h1C), 32'hFFFF_FFFF);
        chk("R6 claim write no error", 32'(bus_err), 32'd0);
        chk("R6 claim write no clear", 32'(clr_pend), 32'd0);
        @(posedge clk); #1;
        check_irq("R6 irq unchanged");
        claim(0, "R6 source still claimable");

        // R7: zero-read offsets
        for (int o = 0; o < 4; o++) begin
            int off = (o == 3) ? 'h18 : 4 * o;
            bus_op(1'b1, AW'(32'h4020 + off), 32'hA5A5_A5A5);
            chk("R7 write accepted", 32'(bus_err), 32'd0);
            bus_op(1'b0, AW'(32'h4020 + off), 32'd0);
            chk("R7 read zero", bus_rdata, 32'd0);
            chk("R7 read no error", 32'(bus_err), 32'd0);
        end

        // R8: error cases
        expect_err(AW'(32'h400C), 1'b0, "R8 window offset 0x0C");
        expect_err(AW'(32'h4034), 1'b1, "R8 window offset 0x14");
        expect_err(AW'(32'h4000 + 32 * NHART + 'h1C), 1'b0, "R8 past last window");
        expect_err(AW'(32'h3000), 1'b0, "R8 below first target");
        expect_err(AW'(32'h3000 + 4 * (NSRC + 1)), 1'b1, "R8 past last target");
        expect_err(AW'(32'h3005), 1'b0, "R8 misaligned");
        rd_tgt(NSRC, "R8 last target still decoded");

        // random phase
        for (int it = 0; it < 600; it++) begin
            int op = int'($urandom_range(0, 6));
            case (op)
                0: raise_src(NSRC'($urandom & $urandom & $urandom));
                1: set_en(NSRC'($urandom), ($urandom_range(0, 7) != 0));
                2: begin
                    int s = int'($urandom_range(1, NSRC));
                    wr_tgt(s, {14'($urandom_range(0, 5)), 18'($urandom)});
                    if ($urandom_range(0, 3) == 0) rd_tgt(s, "R1 random readback");
                end
                3, 4: begin
                    int h = int'($urandom_range(0, NHART - 1));
                    claim(h, "R3 random claim");
                    if ($urandom_range(0, 1) == 1) claim(h, "R4 random back-to-back claim");
                end
                5: begin
                    bus_op(1'b1, AW'(32'h4000 + 32 * $urandom_range(0, NHART - 1) + 'h1C), $urandom);
                    chk("R6 random claim write clear", 32'(clr_pend), 32'd0);
                end
                default: @(posedge clk);
            endcase
            #1;
            check_irq("R9 random irq");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule